// File: doc/BRIEF.md
# Conflict-Triggered Instruction Cache

This block is a small two-way set-associative instruction cache for a three-stage Harvard fetch path. Here the program-memory bus normally carries instruction fetches but sometimes also carries a data access. The cache is consulted only in a cycle where both want the bus at once (a conflict cycle). On a hit, the instruction comes out of the cache and the bus is left to the data access, so nothing stalls. On a miss, the block raises a one-cycle stall. In the cycle after the stall, the bus returns the instruction and the block stores it. Fetches in cycles without a conflict bypass the cache completely.

A freeze input keeps the current contents in place: misses still stall, but nothing is written and the replacement order does not move. A synchronous flush empties the cache. Three counters (conflict hits, conflict misses, evictions of a valid entry) let a core or a testbench spot thrashing, where a few addresses keep evicting each other out of one set.

Top module: `conflict_icache`

## Requirements
- R1: A conflict cycle is a cycle with `fetch_valid`=1 and `pm_data_req`=1 that is not a fill cycle. When the address is present, the block drives `cache_hit`=1, `stall`=0 and `instr_out` equal to the stored instruction, all in that same cycle.
- R2: A conflict cycle that misses drives `stall`=1 for exactly that one cycle. The next cycle is the fill cycle. In the fill cycle `stall`=0, no lookup takes place, and `mem_rdata` is stored for the address that missed.
- R3: In a fetch that is not a conflict, `cache_hit`=0 and `stall`=0, and `instr_out` equals `mem_rdata`. Such a fetch allocates nothing, so a later conflict fetch of the same address misses.
- R4: With the default parameters the set index is address bits [3:0] (address mod 16) and the tag is bits [15:4]. Each set has two ways, so three addresses with the same low nibble cannot all be held at once.
- R5: A fill picks its way as follows. If way 0 is invalid it goes there. Otherwise, if way 1 is invalid, it goes there. Otherwise it replaces the way named by the set's LRU bit. After a fill, and after an unfrozen hit, the LRU bit points at the other way.
- R6: When `freeze`=1 in the miss cycle, the block still stalls, but the fill cycle writes nothing and counts no eviction. When `freeze`=1 in a hit cycle, the hit is still served but the LRU bit does not change. Once `freeze`=0 again, filling works as before.
- R7: A one-cycle `flush` pulse invalidates every entry and clears every LRU bit. A fill that is pending in the cycle of the flush is dropped.
- R8: `hit_cnt` adds one for each conflict hit and `miss_cnt` adds one for each conflict miss. `evict_cnt` adds one for each fill that overwrites a valid entry. Each new count is visible in the cycle after the event.
- R9: After reset every entry is invalid, every counter is zero, and `stall`=0 and `cache_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries and clear all LRU bits |
| freeze | input | 1 | Block fills and LRU updates |
| fetch_valid | input | 1 | Instruction fetch requested this cycle |
| fetch_addr | input | ADDR_W | Instruction address |
| pm_data_req | input | 1 | Data access wants the program-memory bus this cycle |
| mem_rdata | input | DATA_W | Instruction word returned by program memory |
| instr_out | output | DATA_W | Instruction delivered to decode |
| cache_hit | output | 1 | Conflict fetch served from the cache |
| stall | output | 1 | Conflict miss: hold the fetch for one cycle |
| hit_cnt | output | CNT_W | Conflict hit count |
| miss_cnt | output | CNT_W | Conflict miss count |
| evict_cnt | output | CNT_W | Count of fills that replaced a valid entry |

## Verification
A flush can fall in the fill cycle that follows a miss stall, so an invalidate and a write land on the same edge. The bench provokes this by raising `flush` exactly in the cycle after the stall. It judges the outcome at the ports: the flush must win, so a conflict fetch of the same address misses again and `evict_cnt` does not move. A frozen miss is a second case where a stall and a blocked write meet. It is judged the same way, by a repeated miss on the same address.

// File: rtl/cic_pkg.sv
// Shared definitions for the conflict-triggered instruction cache.
// Assumes a fixed associativity of two; way numbers are single bits.
package cic_pkg;
    localparam int WAYS = 2;

    typedef enum logic {
        WAY_A = 1'b0,
        WAY_B = 1'b1
    } way_e;
endpackage

// File: rtl/cic_store.sv
// Entry storage: per-set tags, valid bits, instruction words and LRU bits.
// One combinational read port (the looked-up set), one write port for fills,
// one LRU write port. Flush clears valid and LRU and overrides any write.
module cic_store #(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32,
    localparam int SETS  = 1 << SET_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [SET_W-1:0]            rd_set,
    output logic [1:0][TAG_W-1:0]       rd_tag,
    output logic [1:0]                  rd_valid,
    output logic [1:0][DATA_W-1:0]      rd_data,
    output logic                        rd_lru,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic                        wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        lru_we,
    input  logic [SET_W-1:0]            lru_set,
    input  logic                        lru_val
);
    logic [SETS-1:0] lru_q;

    // Track the replacement bit of each set.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            lru_q <= '0;
        end else if (lru_we) begin
            lru_q[lru_set] <= lru_val;
        end
    end

    assign rd_lru = lru_q[rd_set];

    for (genvar w = 0; w < cic_pkg::WAYS; w++) begin : g_way
        logic [SETS-1:0]   valid_q;
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [DATA_W-1:0] data_q [SETS];

        // Set a valid bit on a fill of this way; reset and flush clear them all.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_q <= '0;
            end else if (wr_en && (wr_way == 1'(w))) begin
                valid_q[wr_set] <= 1'b1;
            end
        end

        // Store tag and instruction word on a fill of this way.
        always_ff @(posedge clk) begin
            if (wr_en && !flush && (wr_way == 1'(w))) begin
                tag_q[wr_set]  <= wr_tag;
                data_q[wr_set] <= wr_data;
            end
        end

        assign rd_valid[w] = valid_q[rd_set];
        assign rd_tag[w]   = tag_q[rd_set];
        assign rd_data[w]  = data_q[rd_set];
    end
endmodule

// File: rtl/cic_lookup.sv
// Tag compare and victim choice for one set. Purely combinational.
// Victim: first invalid way (way 0 first), otherwise the LRU way.
module cic_lookup #(
    parameter int TAG_W = 12
) (
    input  logic [1:0][TAG_W-1:0] rd_tag,
    input  logic [1:0]            rd_valid,
    input  logic                  rd_lru,
    input  logic [TAG_W-1:0]      req_tag,
    output logic                  hit,
    output logic                  hit_way,
    output logic                  victim_way,
    output logic                  victim_valid
);
    logic [1:0] match;

    for (genvar w = 0; w < cic_pkg::WAYS; w++) begin : g_cmp
        assign match[w] = rd_valid[w] && (rd_tag[w] == req_tag);
    end

    // Resolve hit way and replacement way.
    always_comb begin
        hit     = |match;
        hit_way = match[1];
        if (!rd_valid[0]) begin
            victim_way = cic_pkg::WAY_A;
        end else if (!rd_valid[1]) begin
            victim_way = cic_pkg::WAY_B;
        end else begin
            victim_way = rd_lru;
        end
        victim_valid = rd_valid[victim_way];
    end
endmodule

// File: rtl/cic_counters.sv
// Three wrapping event counters for hits, misses and evictions.
module cic_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_hit,
    input  logic             inc_miss,
    input  logic             inc_evict,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt,
    output logic [CNT_W-1:0] evict_cnt
);
    // Count each event in the cycle it is signalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt   <= '0;
            miss_cnt  <= '0;
            evict_cnt <= '0;
        end else begin
            hit_cnt   <= hit_cnt   + CNT_W'(inc_hit);
            miss_cnt  <= miss_cnt  + CNT_W'(inc_miss);
            evict_cnt <= evict_cnt + CNT_W'(inc_evict);
        end
    end
endmodule

// File: rtl/conflict_icache.sv
// Instruction cache consulted only when a data access and an instruction
// fetch want the program-memory bus in the same cycle. Misses stall one
// cycle; the following cycle stores the word from memory. Assumes the core
// holds fetch_addr through the stall and the fill cycle, and that memory
// returns the instruction on mem_rdata in the fill cycle.
module conflict_icache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SET_W  = 4,
    parameter int CNT_W  = 16,
    localparam int TAG_W = ADDR_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              freeze,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              pm_data_req,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] instr_out,
    output logic              cache_hit,
    output logic              stall,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt,
    output logic [CNT_W-1:0]  evict_cnt
);
    logic [SET_W-1:0]        set_idx;
    logic [TAG_W-1:0]        req_tag;
    logic [1:0][TAG_W-1:0]   rd_tag;
    logic [1:0]              rd_valid;
    logic [1:0][DATA_W-1:0]  rd_data;
    logic                    rd_lru;
    logic                    hit, hit_way, victim_way, victim_valid;
    logic                    conflict;

    logic                    fill_pend;
    logic [SET_W-1:0]        fill_set;
    logic [TAG_W-1:0]        fill_tag;
    logic                    fill_way;
    logic                    fill_frozen;
    logic                    fill_evict;
    logic                    wr_en;
    logic                    lru_we;
    logic [SET_W-1:0]        lru_set;
    logic                    lru_val;

    assign set_idx = fetch_addr[SET_W-1:0];
    assign req_tag = fetch_addr[ADDR_W-1:SET_W];

    // A conflict is only recognised outside the fill cycle.
    assign conflict  = fetch_valid && pm_data_req && !fill_pend;
    assign cache_hit = conflict && hit;
    assign stall     = conflict && !hit;
    assign instr_out = cache_hit ? rd_data[hit_way] : mem_rdata;

    // Remember the miss so the next cycle can store the returned word.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            fill_pend <= 1'b0;
        end else begin
            fill_pend <= stall;
        end
    end

    // Capture where the pending fill goes and whether it is allowed.
    always_ff @(posedge clk) begin
        if (stall) begin
            fill_set    <= set_idx;
            fill_tag    <= req_tag;
            fill_way    <= victim_way;
            fill_frozen <= freeze;
            fill_evict  <= victim_valid;
        end
    end

    assign wr_en = fill_pend && !fill_frozen && !flush;

    // Choose the LRU update: fills and unfrozen hits point at the other way.
    always_comb begin
        lru_we  = 1'b0;
        lru_set = set_idx;
        lru_val = 1'b0;
        if (wr_en) begin
            lru_we  = 1'b1;
            lru_set = fill_set;
            lru_val = !fill_way;
        end else if (cache_hit && !freeze) begin
            lru_we  = 1'b1;
            lru_val = !hit_way;
        end
    end

    cic_store #(
        .SET_W  (SET_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_set   (set_idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_lru   (rd_lru),
        .wr_en    (wr_en),
        .wr_set   (fill_set),
        .wr_way   (fill_way),
        .wr_tag   (fill_tag),
        .wr_data  (mem_rdata),
        .lru_we   (lru_we),
        .lru_set  (lru_set),
        .lru_val  (lru_val)
    );

    cic_lookup #(
        .TAG_W (TAG_W)
    ) u_lookup (
        .rd_tag       (rd_tag),
        .rd_valid     (rd_valid),
        .rd_lru       (rd_lru),
        .req_tag      (req_tag),
        .hit          (hit),
        .hit_way      (hit_way),
        .victim_way   (victim_way),
        .victim_valid (victim_valid)
    );

    cic_counters #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_hit   (cache_hit),
        .inc_miss  (stall),
        .inc_evict (wr_en && fill_evict),
        .hit_cnt   (hit_cnt),
        .miss_cnt  (miss_cnt),
        .evict_cnt (evict_cnt)
    );
endmodule

// File: rtl/cic_checker.sv
// Port-level properties of conflict_icache, attached with bind below.
module cic_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             pm_data_req,
    input logic             freeze,
    input logic             cache_hit,
    input logic             stall,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt,
    input logic [CNT_W-1:0] evict_cnt
);
    logic [1:0] cyc;

    // Cycles since reset, saturating at 3, to guard lookbacks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R1
    hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cache_hit && stall));

    // R3
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid && pm_data_req) |-> (!cache_hit && !stall));

    // R2
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0) && $past(stall) |-> !stall);

    // R8
    hit_count_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0) && (hit_cnt != $past(hit_cnt)) |-> $past(cache_hit));

    // R8
    miss_count_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0) && (miss_cnt != $past(miss_cnt)) |-> $past(stall));

    // R6
    frozen_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) && $past(freeze, 2) |-> $stable(evict_cnt));
endmodule

bind conflict_icache cic_checker #(
    .CNT_W (CNT_W)
) u_cic_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .pm_data_req (pm_data_req),
    .freeze      (freeze),
    .cache_hit   (cache_hit),
    .stall       (stall),
    .hit_cnt     (hit_cnt),
    .miss_cnt    (miss_cnt),
    .evict_cnt   (evict_cnt)
);

// File: tb/conflict_icache_bench.sv
`timescale 1ns/1ps
module conflict_icache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        freeze = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        pm_data_req = 1'b0;
    logic [31:0] mem_rdata;
    logic [31:0] instr_out;
    logic        cache_hit, stall;
    logic [15:0] hit_cnt, miss_cnt, evict_cnt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Program memory model: word derived from its address.
    assign mem_rdata = {~fetch_addr, fetch_addr};

    conflict_icache u_conflict_icache (
        .clk(clk), .rst_n(rst_n), .flush(flush), .freeze(freeze),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .pm_data_req(pm_data_req), .mem_rdata(mem_rdata),
        .instr_out(instr_out), .cache_hit(cache_hit), .stall(stall),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .evict_cnt(evict_cnt)
    );

    // Vector: {address[17:2], conflict[1], expected hit[0]}; set 4 walk.
    localparam int NV = 14;
    localparam logic [17:0] VEC [NV] = '{
        {16'h0004, 1'b1, 1'b0}, {16'h0004, 1'b1, 1'b1},
        {16'h0004, 1'b0, 1'b0}, {16'h0014, 1'b1, 1'b0},
        {16'h0004, 1'b1, 1'b1}, {16'h0024, 1'b1, 1'b0},
        {16'h0004, 1'b1, 1'b1}, {16'h0024, 1'b1, 1'b1},
        {16'h0014, 1'b1, 1'b0}, {16'h0004, 1'b1, 1'b0},
        {16'h0014, 1'b1, 1'b1}, {16'h0034, 1'b0, 1'b0},
        {16'h0034, 1'b1, 1'b0}, {16'h0004, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One fetch; a miss is followed by its fill cycle.
    task automatic access(input logic [15:0] a, input logic conf,
                          input logic exp_hit, input string rq);
        @(negedge clk);
        fetch_addr  = a;
        fetch_valid = 1'b1;
        pm_data_req = conf;
        #1;
        chk(cache_hit == exp_hit, {rq, " hit"}, int'(cache_hit), int'(exp_hit));
        chk(stall == (conf && !exp_hit), {rq, " stall"}, int'(stall), int'(conf && !exp_hit));
        if (exp_hit || !conf)
            chk(instr_out == {~a, a}, {rq, " word"}, int'(instr_out), int'({~a, a}));
        if (conf && !exp_hit) begin
            @(negedge clk);
            fetch_valid = 1'b0;
            pm_data_req = 1'b0;
            #1;
            chk(stall == 1'b0, "R2 fill cycle stall", int'(stall), 0);
        end
        @(negedge clk);
        fetch_valid = 1'b0;
        pm_data_req = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        int h0, m0, e0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(hit_cnt == 0 && miss_cnt == 0 && evict_cnt == 0, "R9 counters",
            int'(hit_cnt + miss_cnt + evict_cnt), 0);
        chk(!stall && !cache_hit, "R9 outputs", int'({stall, cache_hit}), 0);

        // R1 R3 R4 R5 table walk on set 4
        for (int i = 0; i < NV; i++)
            access(VEC[i][17:2], VEC[i][1], VEC[i][0], "R1 R3 R4 R5 table");
        chk(hit_cnt == 5, "R8 hit count", int'(hit_cnt), 5);
        chk(miss_cnt == 7, "R8 miss count", int'(miss_cnt), 7);
        chk(evict_cnt == 5, "R8 evict count", int'(evict_cnt), 5);

        // R6 freeze: hits served, misses stall without filling, LRU kept
        freeze = 1'b1;
        e0 = int'(evict_cnt);
        access(16'h0034, 1'b1, 1'b1, "R6 frozen hit");
        access(16'h0044, 1'b1, 1'b0, "R6 frozen miss");
        access(16'h0044, 1'b1, 1'b0, "R6 frozen no fill");
        chk(int'(evict_cnt) == e0, "R6 frozen evict", int'(evict_cnt), e0);
        freeze = 1'b0;
        access(16'h0054, 1'b1, 1'b0, "R6 unfrozen fill");
        access(16'h0004, 1'b1, 1'b1, "R6 lru kept way0");
        access(16'h0034, 1'b1, 1'b0, "R6 lru kept way1 evicted");
        chk(int'(evict_cnt) == e0 + 2, "R6 evict after thaw", int'(evict_cnt), e0 + 2);

        // R7 flush empties; R5 fills use invalid ways without eviction
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        e0 = int'(evict_cnt);
        access(16'h0004, 1'b1, 1'b0, "R7 after flush");
        access(16'h0014, 1'b1, 1'b0, "R5 second way");
        access(16'h0004, 1'b1, 1'b1, "R5 kept way0");
        access(16'h0014, 1'b1, 1'b1, "R5 kept way1");
        chk(int'(evict_cnt) == e0, "R5 no eviction into invalid", int'(evict_cnt), e0);

        // R7 flush in the fill cycle drops the fill
        @(negedge clk);
        fetch_addr = 16'h000A; fetch_valid = 1'b1; pm_data_req = 1'b1;
        #1;
        chk(stall == 1'b1, "R7 setup stall", int'(stall), 1);
        @(negedge clk);
        fetch_valid = 1'b0; pm_data_req = 1'b0; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        e0 = int'(evict_cnt);
        access(16'h000A, 1'b1, 1'b0, "R7 fill dropped");
        access(16'h0004, 1'b1, 1'b0, "R7 set 4 emptied");
        chk(int'(evict_cnt) == e0, "R7 no eviction", int'(evict_cnt), e0);

        // R4 R8 thrash: three addresses in set 6, three rounds
        h0 = int'(hit_cnt); m0 = int'(miss_cnt); e0 = int'(evict_cnt);
        for (int r = 0; r < 3; r++)
            for (int k = 0; k < 3; k++)
                access(16'(16'h0006 + 16'(k) * 16'h0010), 1'b1, 1'b0, "R4 thrash");
        chk(int'(miss_cnt) - m0 == 9, "R8 thrash misses", int'(miss_cnt) - m0, 9);
        chk(int'(evict_cnt) - e0 == 7, "R8 thrash evictions", int'(evict_cnt) - e0, 7);
        chk(int'(hit_cnt) == h0, "R8 thrash hits", int'(hit_cnt), h0);

        summary();
    end
endmodule